// File: doc/BRIEF.md
# Page Buffer Commit Controller

This block is the write path of a small non-volatile-style memory with 256 byte locations. A bus engine in front of it decodes the serial protocol and hands over simple strobes: one that loads the word address, one for each received data byte, one for a Stop condition and one that discards the transfer. Incoming bytes go into an eight-entry page buffer. The low three bits of the address pointer select the entry, and a valid bit marks each entry that has been filled. The pointer steps only within its eight-byte page, so a long burst wraps back to the start of the same page and keeps only the most recent eight bytes.

When a Stop arrives and at least one entry is valid, the block starts a self-timed program cycle of a fixed number of clocks. During that cycle it scans the buffer and copies each valid entry into the array, one byte per clock, through a registered write port that it also brings out. It holds `busy` high for the whole cycle so that the bus engine can withhold acknowledges. All inputs are ignored while `busy` is high, and the cycle cannot be cut short. At the end every valid bit is cleared. An abort strobe received while idle drops the buffered bytes without writing anything. A registered read port lets the array contents be observed.

Top module: `pgbuf_commit_ctrl`

## Requirements
- R1: After reset `busy` and `arr_we` are 0 and no buffer entry is valid, so a Stop with no data that follows reset starts no program cycle.
- R2: `addr_load` sets the pointer to `addr_in`. Each `byte_valid` stores `byte_in` at array address {pointer[7:3], pointer[2:0]} and then increments pointer[2:0] modulo 8, leaving pointer[7:3] unchanged.
- R3: A burst that starts at in-page offset o wraps from offset 7 to offset 0 of the same page. Locations in neighbouring pages are not written.
- R4: When more than 8 bytes arrive before Stop, byte k lands in entry (o+k) mod 8 and a later byte replaces an earlier one, so only the last 8 bytes are committed.
- R5: `stop_strb` while idle starts a program cycle only if at least one entry is valid. Otherwise `busy` stays 0.
- R6: `busy` rises in the clock after the edge that samples `stop_strb` and stays high for exactly PROG_CYCLES clocks.
- R7: During the program cycle `arr_we` pulses once for each valid entry and never for an invalid one, so array locations of the page that received no byte keep their old contents.
- R8: `abort_strb` while idle clears every valid bit. A following Stop with no new data starts no cycle and leaves the array unchanged. Abort takes priority over a Stop or a data byte in the same cycle.
- R9: While `busy` is high, `addr_load`, `byte_valid`, `stop_strb` and `abort_strb` are ignored: the commit completes with the original bytes and the pointer is not changed.
- R10: All valid bits are clear when `busy` falls, so a Stop with no new data after a commit starts no cycle.
- R11: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load the address pointer from `addr_in` |
| addr_in | input | 8 | Word address |
| byte_valid | input | 1 | One received data byte on `byte_in` |
| byte_in | input | 8 | Data byte |
| stop_strb | input | 1 | Stop condition seen on the bus |
| abort_strb | input | 1 | Discard the current transfer |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Registered array read data |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write enable during commit |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench fills all 32 pages and reads back every location. It then drives a single-byte write, a burst that starts at offset 6 and wraps, an eleven-byte overrun, aborted transfers, and a stream of junk strobes sent while a commit runs. A pointer that carried into the upper address bits would write into the next page. A buffer that wrote every entry would overwrite bytes the master never sent, and a design that honoured strobes while busy would lose or corrupt the committed page. The bench also counts the length of `busy` and the write pulses on each commit, so a cycle that ended early, ran long or could be started by an empty Stop shows up as a wrong count.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic {
    CM_IDLE = 1'b0,
    CM_PROG = 1'b1
  } commit_state_t;

  // Next in-page index: the low bits wrap, the page number never changes.
  function automatic logic [2:0] next_slot(input logic [2:0] slot);
    return slot + 3'd1;
  endfunction

endpackage

// File: rtl/pgbuf_ptr.sv
module pgbuf_ptr #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      slot_q <= '0;
    end else if (load) begin
      page_q <= load_addr[ADDR_W-1:IDX_W];
      slot_q <= load_addr[IDX_W-1:0];
    end else if (adv) begin
      slot_q <= slot_q + IDX_W'(1);
    end
  end

  assign ptr = {page_q, slot_q};

  // R3: advancing never moves the pointer out of its page
  a_r3_page_kept: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (ptr[ADDR_W-1:IDX_W] == $past(ptr[ADDR_W-1:IDX_W])));

endmodule

// File: rtl/pgbuf_page_buf.sv
module pgbuf_page_buf #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [(1<<IDX_W)-1:0] valid
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] slot_data [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (hit) slot_data[e] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst || clr) valid[e] <= 1'b0;
      else if (hit)   valid[e] <= 1'b1;
    end
  end

  assign rd_data = slot_data[rd_idx];

endmodule

// File: rtl/pgbuf_commit_fsm.sv
module pgbuf_commit_fsm
  import pgbuf_pkg::*;
#(
  parameter int IDX_W       = 3,
  parameter int PROG_CYCLES = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             scan_en,
  output logic [IDX_W-1:0] scan_idx
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(DEPTH);

  commit_state_t    state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CM_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        CM_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= CM_PROG;
        end
        CM_PROG: begin
          if (cnt_q == LAST) begin
            state_q <= CM_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= CM_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == CM_PROG);
  assign done     = busy && (cnt_q == LAST);
  assign scan_en  = busy && (cnt_q < SCAN_END);
  assign scan_idx = cnt_q[IDX_W-1:0];

  // R6: once started, the cycle runs to its last count without a break
  a_r6_no_halt: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  // R6: the cycle ends right after its last count
  a_r6_ends_after_last: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/pgbuf_commit_ctrl.sv
module pgbuf_commit_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 3,
  parameter int PROG_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_strb,
  input  logic              abort_strb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic              idle;
  logic              load_ok, byte_ok, abort_ok, start_ok;
  logic [ADDR_W-1:0] ptr;
  logic [DEPTH-1:0]  valid;
  logic [DATA_W-1:0] buf_rd;
  logic              done, scan_en;
  logic [IDX_W-1:0]  scan_idx;
  logic              buf_clr;

  assign idle     = !busy;
  assign abort_ok = abort_strb && idle;
  assign load_ok  = addr_load && idle && !abort_strb;
  assign byte_ok  = byte_valid && idle && !abort_strb;
  assign start_ok = stop_strb && idle && !abort_strb && (|valid);
  assign buf_clr  = abort_ok || done;

  pgbuf_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (load_ok),
    .load_addr (addr_in),
    .adv       (byte_ok),
    .ptr       (ptr)
  );

  pgbuf_page_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (byte_ok),
    .wr_idx  (ptr[IDX_W-1:0]),
    .wr_data (byte_in),
    .clr     (buf_clr),
    .rd_idx  (scan_idx),
    .rd_data (buf_rd),
    .valid   (valid)
  );

  pgbuf_commit_fsm #(.IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start_ok),
    .busy     (busy),
    .done     (done),
    .scan_en  (scan_en),
    .scan_idx (scan_idx)
  );

  // Registered write port: one valid entry per clock while scanning.
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we    <= scan_en && valid[scan_idx];
      arr_addr  <= {ptr[ADDR_W-1:IDX_W], scan_idx};
      arr_wdata <= buf_rd;
    end
  end

  pgbuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_addr),
    .wdata (arr_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R5: a cycle only begins on a Stop with buffered data
  a_r5_start_needs_data: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_strb && (|valid)));

  // R7: array writes happen only inside the program cycle
  a_r7_we_in_busy: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R8: an idle abort empties the buffer
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (rst)
    (abort_strb && !busy) |=> (valid == '0));

  // R9: the pointer is frozen during a commit
  a_r9_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ptr));

  // R10: nothing remains valid once the cycle ends
  a_r10_clear_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (valid == '0));

endmodule

// File: tb/pgbuf_commit_ctrl_tb.sv
module pgbuf_commit_ctrl_tb;
  localparam int PROG = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, addr_load, byte_valid, stop_strb, abort_strb;
  logic [7:0] addr_in, byte_in, rd_addr, rd_data, arr_addr, arr_wdata;
  logic       busy, arr_we;

  pgbuf_commit_ctrl #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_in(byte_in), .stop_strb(stop_strb),
    .abort_strb(abort_strb), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [7:0] mdl_mem [256];
  logic [7:0] mdl_buf [8];
  logic       mdl_vld [8];
  logic [7:0] mdl_ptr;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_load(input logic [7:0] a);
    addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
    mdl_ptr = a;
  endtask

  task automatic t_byte(input logic [7:0] d);
    byte_valid = 1; byte_in = d;
    @(negedge clk); byte_valid = 0;
    mdl_buf[mdl_ptr[2:0]] = d;
    mdl_vld[mdl_ptr[2:0]] = 1'b1;
    mdl_ptr = {mdl_ptr[7:3], mdl_ptr[2:0] + 3'd1};
  endtask

  task automatic t_abort();
    abort_strb = 1;
    @(negedge clk); abort_strb = 0;
    for (int i = 0; i < 8; i++) mdl_vld[i] = 1'b0;
  endtask

  task automatic quiet();
    addr_load = 0; byte_valid = 0; stop_strb = 0; abort_strb = 0;
  endtask

  // Stop, then watch the whole cycle; noise=1 throws junk strobes in (R9).
  task automatic t_stop(input string req, input bit noise);
    int n_exp, blen, wes, k;
    n_exp = 0;
    for (int i = 0; i < 8; i++) if (mdl_vld[i]) n_exp++;
    stop_strb = 1;
    @(negedge clk); stop_strb = 0;
    chk({req, " busy after Stop (R5/R6)"}, busy, n_exp > 0);
    if (n_exp > 0) begin
      blen = 0; wes = 0; k = 0;
      while (busy && blen < 100) begin
        quiet();
        blen++;
        if (arr_we) begin
          wes++;
          chk("R3 write stays in page", arr_addr[7:3], mdl_ptr[7:3]);
          chk("R2 write data", arr_wdata, mdl_buf[arr_addr[2:0]]);
        end
        if (noise) begin
          case (k)
            0: abort_strb = 1;
            1: begin addr_load = 1; addr_in = 8'h70; end
            2, 3, 4: begin byte_valid = 1; byte_in = 8'hEE; end
            5: stop_strb = 1;
            default: ;
          endcase
        end
        k++;
        @(negedge clk);
      end
      quiet();
      chk("R6 busy length", blen, PROG);
      chk("R7 write pulse count", wes, n_exp);
      for (int i = 0; i < 8; i++)
        if (mdl_vld[i]) mdl_mem[{mdl_ptr[7:3], 3'(i)}] = mdl_buf[i];
      for (int i = 0; i < 8; i++) mdl_vld[i] = 1'b0;
    end else begin
      repeat (3) begin
        @(negedge clk);
        chk({req, " stays idle"}, busy, 0);
      end
    end
  endtask

  task automatic t_read(input string req, input logic [7:0] a);
    rd_addr = a;
    @(negedge clk);
    chk(req, rd_data, mdl_mem[a]);
  endtask

  task automatic t_read_page(input string req, input logic [7:0] base);
    for (int i = 0; i < 8; i++) t_read(req, base + 8'(i));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    quiet(); addr_in = 0; byte_in = 0; rd_addr = 0;
    for (int i = 0; i < 8; i++) mdl_vld[i] = 1'b0;
    mdl_ptr = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 busy after reset", busy, 0);
    chk("R1 arr_we after reset", arr_we, 0);
    t_stop("R1 empty Stop after reset", 0);

    // R2/R11: fill every page, then sweep every location
    for (int p = 0; p < 32; p++) begin
      t_load(8'(p * 8));
      for (int i = 0; i < 8; i++) t_byte(8'((p * 8 + i) ^ 8'h5A));
      t_stop("R2", 0);
    end
    for (int a = 0; a < 256; a++) t_read("R11 full sweep", 8'(a));

    // R5/R10: Stop right after a commit with nothing new
    t_stop("R10 empty Stop after commit", 0);

    // R7: single byte write leaves the rest of its page alone
    t_load(8'h13); t_byte(8'hC3);
    t_stop("R7", 0);
    t_read_page("R7 byte write page", 8'h10);

    // R3: start at offset 6, four bytes wrap to offsets 0 and 1
    t_load(8'h2E);
    for (int i = 0; i < 4; i++) t_byte(8'hA0 + 8'(i));
    t_stop("R3", 0);
    t_read_page("R3 wrapped page", 8'h28);
    t_read_page("R3 next page untouched", 8'h30);

    // R4: eleven bytes, the last eight win
    t_load(8'h40);
    for (int i = 0; i < 11; i++) t_byte(8'h80 + 8'(i));
    t_stop("R4", 0);
    t_read_page("R4 overrun page", 8'h40);

    // R8: abort then empty Stop
    t_load(8'h50); t_byte(8'h11); t_byte(8'h22); t_byte(8'h33);
    t_abort();
    t_stop("R8 Stop after abort", 0);
    t_read_page("R8 aborted page unchanged", 8'h50);

    // R8: abort beats a same-cycle data byte, then a fresh transfer
    t_load(8'h58); t_byte(8'h44);
    abort_strb = 1; byte_valid = 1; byte_in = 8'h99;
    @(negedge clk); quiet();
    for (int i = 0; i < 8; i++) mdl_vld[i] = 1'b0;
    t_load(8'h5C); t_byte(8'h66);
    t_stop("R8", 0);
    t_read_page("R8 only new byte written", 8'h58);

    // R9: junk strobes during the cycle are ignored
    t_load(8'h60); t_byte(8'h01); t_byte(8'h02);
    t_stop("R9", 1);
    t_read_page("R9 committed page", 8'h60);
    t_read_page("R9 ignored load target", 8'h70);
    t_stop("R10 no leftovers after noisy commit", 0);
    // pointer unchanged by ignored load: next byte goes to 0x62
    t_byte(8'h3C);
    t_stop("R9", 0);
    t_read_page("R9 pointer kept", 8'h60);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule